// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of a shift engine from the module clock. A single configuration word selects one of two division laws. The linear law divides by an even number. The power-of-two law divides by a power of two. The block produces a 50% duty-cycle serial clock level and a clock-enable pulse at every half-period boundary. It also produces two one-cycle strobes, one just before each rising serial edge and one just before each falling serial edge. The shift engine uses these strobes to launch and capture data.

The engine raises `run` while it needs the serial clock. While `run` is low, the divider freezes its phase: the level and the half-period count both stay where they are. A new configuration word is held in a shadow copy. It becomes active at the next half-period boundary while running, or at once while stopped, so the serial clock never carries a shortened half-period. Software chooses the divisor and the module clock rate.

A four-state machine keeps the phase. Its states are `PH_IDLE_LO` and `PH_IDLE_HI` (stopped, level low or high) and `PH_RUN_LO` and `PH_RUN_HI` (counting, level low or high). It has three transitions. *Flip*: from a low state with `run` high and the count at zero, go to `PH_RUN_HI`, and from a high state go to `PH_RUN_LO`. *Park*: with `run` low, go to the idle state of the same level. *Hold*: with `run` high and the count not zero, go to or stay in the running state of the same level.

Top module: `spi_cdiv`

## Requirements
- R1: After reset, `sclk` is low, no strobe or enable is asserted, and the configuration word is zero (power-of-two law, field 0).
- R2: With bit 12 of the configuration set (linear law), the 8-bit field in bits 7:0 holding n gives half-periods of n+1 module cycles, so consecutive rise strobes are 2·(n+1) cycles apart. The smallest division is 2.
- R3: With bit 12 clear (power-of-two law) and the 4-bit field in bits 11:8 holding n ≥ 1, each half-period is 2^(n-1) cycles, so consecutive rise strobes are 2^n cycles apart.
- R4: A power-of-two field of 0 behaves like a field of 1. The level toggles on every cycle, and a strobe is present on every running cycle.
- R5: `rise_stb` is high for exactly the cycle before `sclk` goes from low to high, and `fall_stb` is high for exactly the cycle before `sclk` goes from high to low.
- R6: While `run` is low, `sclk` holds its value and no strobe or enable occurs. When `run` returns, counting resumes from the frozen count.
- R7: A write while running leaves the current half-period at its old length. The new law takes effect from the next half-period boundary.
- R8: A write while stopped becomes active on the following cycle. The count restarts with a full half-period of the new setting, and the level is kept.
- R9: `sclk_en` is high exactly in the cycles after whose clock edge `sclk` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 13 | Configuration word: linear field 7:0, power field 11:8, law select 12 |
| run | input | 1 | Shift engine active; low freezes the phase |
| sclk | output | 1 | Serial clock level |
| sclk_en | output | 1 | Half-period boundary enable |
| rise_stb | output | 1 | One cycle before a rising serial edge |
| fall_stb | output | 1 | One cycle before a falling serial edge |

## Verification
Four properties are checked on every cycle. Each strobe must be followed by the matching level, the level must stay frozen while `run` is low, and the level may change only after an enable pulse and must change after every one. The actual division ratios under both laws, the field-0 case, and the points at which a write takes effect (deferred while running, immediate while stopped) are visible only through the bench's scenarios. There, a per-cycle reference model and an independent measure of the spacing between rise strobes are compared against the outputs.

// File: rtl/spi_cdiv_pkg.sv
package spi_cdiv_pkg;

    // Phase state: idle/running crossed with the serial level
    typedef enum logic [1:0] {
        PH_IDLE_LO = 2'b00,
        PH_IDLE_HI = 2'b01,
        PH_RUN_LO  = 2'b10,
        PH_RUN_HI  = 2'b11
    } phase_e;

    // Division law selected by the top bit of the configuration word
    typedef enum logic {
        LAW_POW2 = 1'b0,
        LAW_LIN  = 1'b1
    } law_e;

endpackage

// File: rtl/spi_cdiv_cfg.sv
module spi_cdiv_cfg #(
    parameter int LIN_W = 8,
    parameter int POW_W = 4,
    localparam int CFG_W = LIN_W + POW_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             apply_ok,
    output logic [CFG_W-1:0] eff_cfg,
    output logic             apply
);

    logic [CFG_W-1:0] shadow_q;
    logic [CFG_W-1:0] active_q;
    logic             pend_q;

    assign apply   = pend_q && apply_ok;
    assign eff_cfg = apply ? shadow_q : active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (we) begin
                shadow_q <= wdata;
            end
            if (apply) begin
                active_q <= shadow_q;
            end
            if (we) begin
                pend_q <= 1'b1;
            end else if (apply) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_cdiv_law.sv
module spi_cdiv_law
    import spi_cdiv_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int POW_W = 4,
    localparam int CFG_W = LIN_W + POW_W + 1,
    localparam int PMAX  = (1 << POW_W) - 1,
    localparam int CNT_W = (LIN_W > PMAX) ? LIN_W : PMAX
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [CNT_W-1:0] half_m1
);

    law_e             law;
    logic [LIN_W-1:0] lin_n;
    logic [POW_W-1:0] pow_n;
    logic [CNT_W-1:0] lin_half;
    logic [CNT_W-1:0] pow_half;

    assign law   = law_e'(cfg[CFG_W-1]);
    assign lin_n = cfg[LIN_W-1:0];
    assign pow_n = cfg[LIN_W+POW_W-1:LIN_W];

    // Linear: half-period n+1 cycles, so reload n
    assign lin_half = CNT_W'(lin_n);

    // Power of two: half-period 2^(n-1), field 0 folds onto field 1
    always_comb begin
        if (pow_n == '0) begin
            pow_half = '0;
        end else begin
            pow_half = (CNT_W'(1) << (pow_n - POW_W'(1))) - CNT_W'(1);
        end
    end

    always_comb begin
        unique case (law)
            LAW_LIN:  half_m1 = lin_half;
            LAW_POW2: half_m1 = pow_half;
            default:  half_m1 = '0;
        endcase
    end

endmodule

// File: rtl/spi_cdiv_fsm.sv
module spi_cdiv_fsm
    import spi_cdiv_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             idle_load,
    input  logic [CNT_W-1:0] reload,
    output logic             sclk,
    output logic             tick,
    output logic             rise,
    output logic             fall
);

    phase_e           state_q;
    phase_e           state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             zero;

    assign zero = (cnt_q == '0);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE_LO, PH_RUN_LO: begin
                if (!run)      state_d = PH_IDLE_LO;   // park
                else if (zero) state_d = PH_RUN_HI;    // flip
                else           state_d = PH_RUN_LO;    // hold
            end
            PH_IDLE_HI, PH_RUN_HI: begin
                if (!run)      state_d = PH_IDLE_HI;   // park
                else if (zero) state_d = PH_RUN_LO;    // flip
                else           state_d = PH_RUN_HI;    // hold
            end
            default: state_d = PH_IDLE_LO;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // half-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= zero ? reload : (cnt_q - CNT_W'(1));
        end else if (idle_load) begin
            cnt_q <= reload;
        end
    end

    // outputs
    always_comb begin
        tick = run && zero;
        unique case (state_q)
            PH_IDLE_LO, PH_RUN_LO: begin
                sclk = 1'b0;
                rise = tick;
                fall = 1'b0;
            end
            PH_IDLE_HI, PH_RUN_HI: begin
                sclk = 1'b1;
                rise = 1'b0;
                fall = tick;
            end
            default: begin
                sclk = 1'b0;
                rise = 1'b0;
                fall = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spi_cdiv.sv
module spi_cdiv #(
    parameter int LIN_W = 8,
    parameter int POW_W = 4,
    localparam int CFG_W = LIN_W + POW_W + 1,
    localparam int PMAX  = (1 << POW_W) - 1,
    localparam int CNT_W = (LIN_W > PMAX) ? LIN_W : PMAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             run,
    output logic             sclk,
    output logic             sclk_en,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [CFG_W-1:0] eff_cfg;
    logic             apply;
    logic [CNT_W-1:0] half_m1;
    logic             tick;

    spi_cdiv_cfg #(.LIN_W(LIN_W), .POW_W(POW_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .apply_ok (!run || tick),
        .eff_cfg  (eff_cfg),
        .apply    (apply)
    );

    spi_cdiv_law #(.LIN_W(LIN_W), .POW_W(POW_W)) u_law (
        .cfg     (eff_cfg),
        .half_m1 (half_m1)
    );

    spi_cdiv_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .idle_load (apply && !run),
        .reload    (half_m1),
        .sclk      (sclk),
        .tick      (tick),
        .rise      (rise_stb),
        .fall      (fall_stb)
    );

    assign sclk_en = tick;

endmodule

// File: rtl/spi_cdiv_chk.sv
module spi_cdiv_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic sclk,
    input logic sclk_en,
    input logic rise_stb,
    input logic fall_stb
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_rise_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> sclk);

    assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !sclk);

    assert_frozen_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(sclk));

    assert_enable_marks_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((sclk != $past(sclk)) == $past(sclk_en)));

endmodule

bind spi_cdiv spi_cdiv_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sclk     (sclk),
    .sclk_en  (sclk_en),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
);

// File: tb/spi_cdiv_tb.sv
`timescale 1ns/1ps
module spi_cdiv_tb;

    localparam int CFG_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             run = 1'b0;
    logic             sclk, sclk_en, rise_stb, fall_stb;

    spi_cdiv u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .run       (run),
        .sclk      (sclk),
        .sclk_en   (sclk_en),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb)
    );

    always #4 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    m_lvl = 0, m_cnt = 0, m_sh = 0, m_act = 0, m_pend = 0;
    int    cyc_no = 0;
    int    last_rise = -1;
    int    exp_period = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // half-period minus one, from the requirement formulas
    function automatic int half_m1(int cfg);
        int n;
        if (((cfg >> 12) & 1) == 1) return cfg & 255;
        n = (cfg >> 8) & 15;
        if (n == 0) return 0;
        return (2 ** (n - 1)) - 1;
    endfunction

    task automatic check(string rq, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc_no);
        end
    endtask

    task automatic step(bit r, bit we, int wd);
        bit tick, apply;
        @(negedge clk);
        run = r; cfg_we = we; cfg_wdata = wd[CFG_W-1:0];
        #1;
        tick = r && (m_cnt == 0);
        check(tag, "sclk", int'(sclk), m_lvl);
        check(tag, "rise_stb", int'(rise_stb), int'(tick && m_lvl == 0));
        check(tag, "fall_stb", int'(fall_stb), int'(tick && m_lvl == 1));
        check(tag, "sclk_en", int'(sclk_en), int'(tick));
        cyc_no++;
        if (rise_stb) begin
            if (exp_period > 0 && last_rise >= 0)
                check(tag, "rise spacing", cyc_no - last_rise, exp_period);
            last_rise = cyc_no;
        end
        apply = (m_pend != 0) && (!r || tick);
        if (r) begin
            if (tick) begin
                m_lvl = 1 - m_lvl;
                m_cnt = half_m1(apply ? m_sh : m_act);
            end else begin
                m_cnt = m_cnt - 1;
            end
        end else if (apply) begin
            m_cnt = half_m1(m_sh);
        end
        if (apply) m_act = m_sh;
        if (we) m_pend = 1; else if (apply) m_pend = 0;
        if (we) m_sh = wd;
    endtask

    task automatic go(bit r, int n);
        for (int i = 0; i < n; i++) step(r, 1'b0, 0);
    endtask

    // write while stopped, then measure a running stretch
    task automatic idle_cfg(string t, int wd, int period, int n);
        tag = "R8";
        step(1'b0, 1'b1, wd);
        go(1'b0, 2);
        tag = t;
        exp_period = period;
        last_rise = -1;
        go(1'b1, n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        go(1'b0, 3);

        idle_cfg("R2/R5/R9", 'h1002, 6, 40);

        tag = "R6";
        go(1'b0, 7);
        tag = "R6/R2";
        last_rise = -1;
        go(1'b1, 30);

        idle_cfg("R2", 'h1000, 2, 20);
        idle_cfg("R3/R5", 'h0300, 8, 40);
        idle_cfg("R3", 'h0500, 32, 100);
        idle_cfg("R4", 'h0000, 2, 12);
        idle_cfg("R4", 'h0100, 2, 12);

        idle_cfg("R2", 'h1003, 8, 20);
        tag = "R7";
        exp_period = 0;
        step(1'b1, 1'b1, 'h1001);
        go(1'b1, 12);
        exp_period = 4;
        last_rise = -1;
        go(1'b1, 20);
        exp_period = 0;
        step(1'b1, 1'b1, 'h0200);
        go(1'b1, 8);
        exp_period = 4;
        last_rise = -1;
        go(1'b1, 20);

        tag = "R6/R8";
        exp_period = 0;
        go(1'b0, 3);
        step(1'b0, 1'b1, 'h1004);
        go(1'b0, 4);
        exp_period = 10;
        last_rise = -1;
        go(1'b1, 40);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule